// File: doc/BRIEF.md
# SPI Slave with Switchable Line Usage

This block is an SPI slave for 8-bit frames, clocked by a fast system clock. It uses SPI mode 0: data is sampled on rising SCK and shifted on falling SCK. The serial lines SCK, chip select, MOSI and the MISO pad input are each passed through a two-flop synchronizer, and edges are detected in the system domain. One 8-bit transmit holding register and one 8-bit receive holding register sit on either side of the shifting logic. The transmit byte is sent most significant bit first.

Three configuration inputs choose how the lines are used:

| Mode | `cfg_bidir` | `cfg_rxonly` | `cfg_dir_out` | Behaviour |
|---|---|---|---|---|
| Full duplex | 0 | 0 | don't care | Sends on MISO and receives on MOSI |
| Receive-only | 0 | 1 | don't care | Listens on MOSI and never drives MISO |
| One-wire, transmit | 1 | don't care | 1 | MISO pad is the output |
| One-wire, receive | 1 | don't care | 0 | MISO pad is the input |

The MISO pad is exposed as separate in, out and enable signals so that it can be turned around.

Software writes a byte with a write strobe and reads the received byte with a read strobe. The status outputs are:
- `tx_empty`: the holding register has moved into the shifter.
- `rx_full`: a complete byte is waiting.
- `busy`: a frame is underway.

Two enable inputs gate the two buffer flags onto interrupt lines.

Top module: `spi_slave_bidir`

## Requirements
- R1: After synchronous reset, `tx_empty`=1, `rx_full`=0, `busy`=0, `miso_oe`=0, `rd_data`=0 and both interrupt outputs are 0.
- R2: In full duplex (`cfg_bidir`=0, `cfg_rxonly`=0), the byte in the transmit register appears on `miso_o` MSB first, one bit per SCK cycle, valid before each rising edge. The 8 bits sampled from `mosi` on the rising edges, MSB first, appear on `rd_data` with `rx_full`=1 after the eighth rising edge.
- R3: `tx_empty` drops to 0 on a write strobe. It rises to 1 when the held byte is loaded into the shifter, which happens at chip-select assertion or at the falling SCK edge that follows a completed frame. `irq_tx` equals `tx_empty` AND `ie_tx`.
- R4: A read strobe clears `rx_full`. `irq_rx` equals `rx_full` AND `ie_rx`.
- R5: A second write while `tx_empty`=0 replaces the held byte, and only the later byte is transmitted.
- R6: In receive-only mode (`cfg_bidir`=0, `cfg_rxonly`=1), `miso_oe` stays 0 and the byte is received from `mosi`.
- R7: In one-wire transmit mode (`cfg_bidir`=1, `cfg_dir_out`=1), the held byte is sent on `miso_o` with `miso_oe`=1, and nothing is received: `rx_full` stays 0 and `rd_data` keeps its value.
- R8: In one-wire receive mode (`cfg_bidir`=1, `cfg_dir_out`=0), the byte is taken from `miso_i`, `mosi` is ignored, and `miso_oe` stays 0.
- R9: `busy` is 1 from the first rising SCK edge of a frame until its eighth rising edge. It is 0 whenever chip select is high.
- R10: Raising `cs_n` mid-frame aborts the frame. `rx_full` is not set, and the next frame starts again from bit 7.
- R11: A byte that completes while `rx_full` is still 1 overwrites `rd_data`.
- R12: With `cs_n` held low, frames follow back to back. The second frame sends the byte written during the first frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Read strobe; clears `rx_full` |
| rd_data | output | 8 | Receive holding register |
| cfg_bidir | input | 1 | 1 selects one-wire operation on the MISO pad |
| cfg_rxonly | input | 1 | 1 selects receive-only when `cfg_bidir`=0 |
| cfg_dir_out | input | 1 | One-wire direction: 1 transmit, 0 receive |
| ie_tx | input | 1 | Interrupt enable for `tx_empty` |
| ie_rx | input | 1 | Interrupt enable for `rx_full` |
| tx_empty | output | 1 | Transmit holding register free |
| rx_full | output | 1 | Receive holding register holds an unread byte |
| busy | output | 1 | Frame in progress |
| irq_tx | output | 1 | Gated `tx_empty` interrupt |
| irq_rx | output | 1 | Gated `rx_full` interrupt |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Master-out serial data |
| miso_i | input | 1 | MISO pad input, used in one-wire receive mode |
| miso_o | output | 1 | MISO pad output |
| miso_oe | output | 1 | MISO pad output enable |

## Verification
Faults inside the block reach the ports at different speeds:
- **Bit counter:** an off-by-one error shows within one frame. `rx_full` rises after the wrong rising edge, and `rd_data` comes back rotated.
- **Mode decoder:** a wrong decode shows on the very first bit. `miso_oe` rises in a listening mode, or the byte is taken from the wrong pin.
- **Load or abort logic:** a stale load, or an abort that leaves residue, shows only on the frame after the one that caused it. For that reason the bench checks frames in pairs: an aborted frame followed by a full one, and back-to-back frames under a single chip select.

// File: rtl/spi_sb_pkg.sv
package spi_sb_pkg;

  typedef enum logic [1:0] {
    LINE_DUPLEX  = 2'd0,
    LINE_LISTEN  = 2'd1,
    LINE_WIRE_TX = 2'd2,
    LINE_WIRE_RX = 2'd3
  } line_mode_e;

  typedef struct packed {
    logic tx_en;
    logic rx_en;
    logic rx_pad;
  } line_use_t;

  function automatic line_mode_e pick_mode(input logic bidir, input logic rxonly,
                                           input logic dir_out);
    if (bidir) return dir_out ? LINE_WIRE_TX : LINE_WIRE_RX;
    return rxonly ? LINE_LISTEN : LINE_DUPLEX;
  endfunction

  function automatic line_use_t mode_use(input line_mode_e m);
    line_use_t u;
    case (m)
      LINE_DUPLEX:  u = '{tx_en: 1'b1, rx_en: 1'b1, rx_pad: 1'b0};
      LINE_LISTEN:  u = '{tx_en: 1'b0, rx_en: 1'b1, rx_pad: 1'b0};
      LINE_WIRE_TX: u = '{tx_en: 1'b1, rx_en: 1'b0, rx_pad: 1'b0};
      default:      u = '{tx_en: 1'b0, rx_en: 1'b1, rx_pad: 1'b1};
    endcase
    return u;
  endfunction

endpackage

// File: rtl/spi_sb_sync.sv
module spi_sb_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_sb_shifter.sv
module spi_sb_shifter #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sck_s,
  input  logic               csn_s,
  input  logic               din_s,
  input  logic               tx_en,
  input  logic               rx_en,
  input  logic [FRAME_W-1:0] load_data,
  output logic               load_p,
  output logic               done_p,
  output logic [FRAME_W-1:0] rx_word,
  output logic               busy,
  output logic               ser_out
);
  localparam int CNT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic               sck_q, csn_q, active;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] tx_sh, rx_sh;
  logic               rise, fall, cs_fall;

  assign rise    = sck_s & ~sck_q;
  assign fall    = ~sck_s & sck_q;
  assign cs_fall = ~csn_s & csn_q;
  assign ser_out = tx_sh[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q   <= 1'b0;
      csn_q   <= 1'b1;
      active  <= 1'b0;
      cnt     <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_word <= '0;
      load_p  <= 1'b0;
      done_p  <= 1'b0;
      busy    <= 1'b0;
    end else begin
      sck_q  <= sck_s;
      csn_q  <= csn_s;
      load_p <= 1'b0;
      done_p <= 1'b0;
      if (csn_s) begin
        active <= 1'b0;
        cnt    <= '0;
        busy   <= 1'b0;
      end else if (cs_fall || (fall && !active)) begin
        active <= 1'b1;
        cnt    <= '0;
        load_p <= tx_en;
        if (tx_en) tx_sh <= load_data;
      end else if (rise && active) begin
        rx_sh <= {rx_sh[FRAME_W-2:0], din_s};
        if (cnt == LAST) begin
          cnt     <= '0;
          active  <= 1'b0;
          busy    <= 1'b0;
          done_p  <= rx_en;
          rx_word <= {rx_sh[FRAME_W-2:0], din_s};
        end else begin
          cnt  <= cnt + 1'b1;
          busy <= 1'b1;
        end
      end else if (fall && active && cnt != '0) begin
        tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_sb_bufs.sv
module spi_sb_bufs #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [FRAME_W-1:0] wr_data,
  input  logic               rd_en,
  input  logic               load_p,
  input  logic               done_p,
  input  logic [FRAME_W-1:0] rx_word,
  output logic [FRAME_W-1:0] tx_buf,
  output logic [FRAME_W-1:0] rx_buf,
  output logic               txe,
  output logic               rxne
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_buf <= '0;
      rx_buf <= '0;
      txe    <= 1'b1;
      rxne   <= 1'b0;
    end else begin
      if (load_p) txe <= 1'b1;
      if (wr_en) begin
        tx_buf <= wr_data;
        txe    <= 1'b0;
      end
      if (rd_en) rxne <= 1'b0;
      if (done_p) begin
        rx_buf <= rx_word;
        rxne   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_slave_bidir.sv
module spi_slave_bidir #(
  parameter int FRAME_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [FRAME_W-1:0] wr_data,
  input  logic               rd_en,
  output logic [FRAME_W-1:0] rd_data,
  input  logic               cfg_bidir,
  input  logic               cfg_rxonly,
  input  logic               cfg_dir_out,
  input  logic               ie_tx,
  input  logic               ie_rx,
  output logic               tx_empty,
  output logic               rx_full,
  output logic               busy,
  output logic               irq_tx,
  output logic               irq_rx,
  input  logic               sck,
  input  logic               cs_n,
  input  logic               mosi,
  input  logic               miso_i,
  output logic               miso_o,
  output logic               miso_oe
);
  import spi_sb_pkg::*;

  localparam int PINS = 4;

  logic [PINS-1:0]    pins_s;
  logic               sck_s, csn_s, mosi_s, misoi_s, din_s;
  logic               load_p, done_p;
  logic [FRAME_W-1:0] rx_word, tx_buf;
  line_use_t          use_q;

  spi_sb_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES), .RST_VAL(4'b0010)) sync_i (
    .clk(clk), .rst(rst), .d({miso_i, mosi, cs_n, sck}), .q(pins_s)
  );

  assign sck_s   = pins_s[0];
  assign csn_s   = pins_s[1];
  assign mosi_s  = pins_s[2];
  assign misoi_s = pins_s[3];

  assign use_q = mode_use(pick_mode(cfg_bidir, cfg_rxonly, cfg_dir_out));
  assign din_s = use_q.rx_pad ? misoi_s : mosi_s;

  spi_sb_shifter #(.FRAME_W(FRAME_W)) shf_i (
    .clk(clk), .rst(rst), .sck_s(sck_s), .csn_s(csn_s), .din_s(din_s),
    .tx_en(use_q.tx_en), .rx_en(use_q.rx_en), .load_data(tx_buf),
    .load_p(load_p), .done_p(done_p), .rx_word(rx_word), .busy(busy),
    .ser_out(miso_o)
  );

  spi_sb_bufs #(.FRAME_W(FRAME_W)) buf_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .load_p(load_p), .done_p(done_p), .rx_word(rx_word),
    .tx_buf(tx_buf), .rx_buf(rd_data), .txe(tx_empty), .rxne(rx_full)
  );

  always_ff @(posedge clk) begin
    if (rst) miso_oe <= 1'b0;
    else     miso_oe <= ~csn_s & use_q.tx_en;
  end

  assign irq_tx = tx_empty & ie_tx;
  assign irq_rx = rx_full & ie_rx;
endmodule

// File: rtl/spi_sb_checker.sv
module spi_sb_checker (
  input logic clk,
  input logic rst,
  input logic csn_s,
  input logic load_p,
  input logic done_p,
  input logic wr_en,
  input logic rd_en,
  input logic tx_empty,
  input logic rx_full,
  input logic busy,
  input logic miso_oe,
  input logic cfg_bidir,
  input logic cfg_rxonly,
  input logic cfg_dir_out
);
  p_write_clears_txe_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !tx_empty);

  p_txe_rises_only_on_load_r3: assert property (@(posedge clk) disable iff (rst)
    (!tx_empty && !load_p) |=> !tx_empty);

  p_read_clears_rxne_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !done_p) |=> !rx_full);

  p_done_sets_rxne_r2: assert property (@(posedge clk) disable iff (rst)
    done_p |=> rx_full);

  p_listen_no_drive_r6: assert property (@(posedge clk) disable iff (rst)
    (!cfg_bidir && cfg_rxonly) |=> !miso_oe);

  p_wire_rx_no_drive_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_bidir && !cfg_dir_out) |=> !miso_oe);

  p_idle_not_busy_r9: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> (!busy && !miso_oe));

  p_abort_no_rxne_r10: assert property (@(posedge clk) disable iff (rst)
    (csn_s && !rx_full) |=> !rx_full);
endmodule

bind spi_slave_bidir spi_sb_checker chk_i (
  .clk(clk), .rst(rst), .csn_s(csn_s), .load_p(load_p), .done_p(done_p),
  .wr_en(wr_en), .rd_en(rd_en), .tx_empty(tx_empty), .rx_full(rx_full),
  .busy(busy), .miso_oe(miso_oe), .cfg_bidir(cfg_bidir),
  .cfg_rxonly(cfg_rxonly), .cfg_dir_out(cfg_dir_out)
);

// File: tb/spi_slave_bidir_tb.sv
module spi_slave_bidir_tb_top;
  localparam int HALF = 8;
  localparam int NVEC = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic cfg_bidir = 1'b0, cfg_rxonly = 1'b0, cfg_dir_out = 1'b0;
  logic ie_tx = 1'b0, ie_rx = 1'b0;
  logic tx_empty, rx_full, busy, irq_tx, irq_rx;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, miso_i = 1'b0;
  logic miso_o, miso_oe;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_slave_bidir dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .cfg_bidir(cfg_bidir), .cfg_rxonly(cfg_rxonly),
    .cfg_dir_out(cfg_dir_out), .ie_tx(ie_tx), .ie_rx(ie_rx),
    .tx_empty(tx_empty), .rx_full(rx_full), .busy(busy), .irq_tx(irq_tx),
    .irq_rx(irq_rx), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso_i(miso_i),
    .miso_o(miso_o), .miso_oe(miso_oe)
  );

  // {mode[26:25], tx[24:17], line[16:9], exp_rxne[8], exp_rx[7:0]}
  // mode 0 duplex, 1 receive-only, 2 one-wire tx, 3 one-wire rx
  localparam logic [26:0] VEC [NVEC] = '{
    {2'd0, 8'hA5, 8'h3C, 1'b1, 8'h3C},
    {2'd0, 8'h01, 8'h80, 1'b1, 8'h80},
    {2'd1, 8'h00, 8'h5A, 1'b1, 8'h5A},
    {2'd2, 8'hC3, 8'hFF, 1'b0, 8'h5A},
    {2'd3, 8'h00, 8'h96, 1'b1, 8'h96},
    {2'd0, 8'hFF, 8'h00, 1'b1, 8'h00},
    {2'd2, 8'h7E, 8'h11, 1'b0, 8'h00},
    {2'd0, 8'h00, 8'hFF, 1'b1, 8'hFF}
  };

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic read_pulse();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    cfg_bidir   = m[1];
    cfg_dir_out = (m == 2'd2);
    cfg_rxonly  = (m == 2'd1);
  endtask

  task automatic shift_bits(input logic [7:0] line, input int nbits, input bit on_pad,
                            output logic [7:0] got, output bit oe_any, output bit busy_mid);
    got = '0; oe_any = 0; busy_mid = 0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi   = on_pad ? ~line[i] : line[i];
      miso_i = on_pad ? line[i] : ~line[i];
      ticks(HALF);
      got[i] = miso_o;
      if (miso_oe) oe_any = 1;
      sck = 1'b1;
      ticks(HALF);
      if (i == 4) busy_mid = busy;
      sck = 1'b0;
    end
  endtask

  task automatic cs_drop();
    cs_n = 1'b0; ticks(HALF);
  endtask

  task automatic cs_raise();
    ticks(HALF); cs_n = 1'b1; ticks(HALF);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] got, got2;
    bit oe_any, busy_mid;

    ticks(4); rst = 1'b0; ticks(2);
    // R1 reset state
    check("R1 tx_empty", tx_empty, 1);
    check("R1 rx_full", rx_full, 0);
    check("R1 busy", busy, 0);
    check("R1 miso_oe", miso_oe, 0);
    check("R1 rd_data", rd_data, 0);
    check("R1 irqs", {irq_tx, irq_rx}, 0);

    // vector table: R2 R6 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] m;
      m = VEC[v][26:25];
      read_pulse();
      set_mode(m);
      if (m == 2'd0 || m == 2'd2) write_byte(VEC[v][24:17]);
      cs_drop();
      shift_bits(VEC[v][16:9], 8, (m == 2'd3), got, oe_any, busy_mid);
      cs_raise();
      if (m == 2'd0 || m == 2'd2) check("R2/R7 miso byte", got, VEC[v][24:17]);
      else check("R6/R8 miso_oe held low", oe_any, 0);
      check("R2/R6/R7/R8 rx_full", rx_full, VEC[v][8]);
      check("R2/R6/R7/R8 rd_data", rd_data, VEC[v][7:0]);
    end

    // R3 and R4: flags and interrupts
    set_mode(2'd0); ie_tx = 1'b1; ie_rx = 1'b1;
    read_pulse();
    write_byte(8'h5C);
    check("R3 tx_empty after write", tx_empty, 0);
    check("R3 irq_tx low", irq_tx, 0);
    cs_drop();
    check("R3 tx_empty after load", tx_empty, 1);
    check("R3 irq_tx high", irq_tx, 1);
    shift_bits(8'h21, 8, 0, got, oe_any, busy_mid);
    // R9 busy during the frame
    check("R9 busy mid-frame", busy_mid, 1);
    cs_raise();
    check("R9 busy after frame", busy, 0);
    check("R4 irq_rx set", irq_rx, 1);
    read_pulse();
    check("R4 rx_full cleared", rx_full, 0);
    check("R4 irq_rx cleared", irq_rx, 0);
    ie_tx = 1'b0; ie_rx = 1'b0;

    // R5 overwrite of held byte
    write_byte(8'h11);
    write_byte(8'h22);
    cs_drop();
    shift_bits(8'h00, 8, 0, got, oe_any, busy_mid);
    cs_raise();
    check("R5 later byte sent", got, 8'h22);

    // R10 abort mid-frame then full frame
    read_pulse();
    write_byte(8'hE7);
    cs_drop();
    shift_bits(8'hFF, 3, 0, got, oe_any, busy_mid);
    cs_raise();
    check("R10 no rx_full after abort", rx_full, 0);
    check("R10 busy low after abort", busy, 0);
    write_byte(8'h4B);
    cs_drop();
    shift_bits(8'hA1, 8, 0, got, oe_any, busy_mid);
    cs_raise();
    check("R10 clean restart rx", rd_data, 8'hA1);
    check("R10 clean restart tx", got, 8'h4B);

    // R11 overwrite of unread byte
    cs_drop();
    shift_bits(8'h12, 8, 0, got, oe_any, busy_mid);
    cs_raise();
    cs_drop();
    shift_bits(8'h34, 8, 0, got, oe_any, busy_mid);
    cs_raise();
    check("R11 rx_full still set", rx_full, 1);
    check("R11 newest byte kept", rd_data, 8'h34);

    // R12 back-to-back frames under one chip select
    read_pulse();
    write_byte(8'h9C);
    cs_drop();
    write_byte(8'h63);
    shift_bits(8'hD2, 8, 0, got, oe_any, busy_mid);
    shift_bits(8'h2D, 8, 0, got2, oe_any, busy_mid);
    cs_raise();
    check("R12 first byte", got, 8'h9C);
    check("R12 second byte", got2, 8'h63);
    check("R12 second rx byte", rd_data, 8'h2D);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule